// File: doc/BRIEF.md
# Modem Handshake Status and Control Unit

This block holds the modem handshake state of one serial channel. It watches four active-low modem lines from the data set: clear-to-send, data-set-ready, ring indicator and carrier detect. Each line passes through a synchronizer before the block uses it. The block presents a status byte that carries the live level of each line and a sticky change flag for each line. The change flags clear when the status byte is read. While any change flag is set and the interrupt enable is high, the block raises a modem-status interrupt request.

A control byte, written by the bus decoder, drives three active-low outputs: terminal-ready, request-to-send and auxiliary output 2. A loop flag in the control byte forces these outputs to their inactive high level. In loop mode the status byte also reads back the control bits instead of the pins, so software can exercise the handshake path without a data set attached. The CTS and DCD lines only feed status and have no effect on any data path.

Top module: `modem_ctl_unit`

## Requirements
- R1: While `mr` is high, and on the first sampling after it falls, `dtr_n`, `rts_n` and `out2_n` are high, `msi_irq` is low, `ctrl_q` is 0 and `status_q[3:0]` is 0.
- R2: Outside loop mode, `status_q[4]` = NOT cts_n, `status_q[5]` = NOT dsr_n, `status_q[6]` = NOT ri_n and `status_q[7]` = NOT dcd_n. A pin change appears two clock edges after the pin is sampled.
- R3: `status_q[0]` (CTS), `status_q[1]` (DSR) and `status_q[3]` (DCD) are set by any toggle of their line, one edge after the live bit changes. They stay set until a status read.
- R4: `status_q[2]` is set only when the ring line goes inactive, which is a low-to-high change of `ri_n`. A high-to-low change leaves it clear.
- R5: A cycle with `status_rd` high clears `status_q[3:0]` at that clock edge. A change that is due to set a flag at the same edge still sets it, so the event is not lost.
- R6: `msi_irq` = `msi_en` AND (any of `status_q[3:0]` set). It falls after the clearing read. With `msi_en` low it stays low even while flags are set.
- R7: A write with `ctrl_wr` high stores `wr_data[4:0]`, and `ctrl_q` reads it back with bits 7:5 at 0. Control bit 0 = 1 drives `dtr_n` low, bit 1 drives `rts_n` low and bit 3 drives `out2_n` low, from the edge of the write. Bit 2 is auxiliary output 1, which is internal.
- R8: Control bit 4 is loop mode. In loop mode `dtr_n`, `rts_n` and `out2_n` are high and the pins are ignored. The live status bits come from the control bits instead: bit 4 from RTS (ctrl bit 1), bit 5 from DTR (ctrl bit 0), bit 6 from OUT1 (ctrl bit 2) and bit 7 from OUT2 (ctrl bit 3). The change flags follow these looped values under the same rules as R3 and R4.
- R9: Asserting `mr` during operation clears the control byte, all change flags and the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mr | input | 1 | Master reset, active high, synchronous |
| cts_n | input | 1 | Clear-to-send line, active low, asynchronous |
| dsr_n | input | 1 | Data-set-ready line, active low, asynchronous |
| ri_n | input | 1 | Ring indicator line, active low, asynchronous |
| dcd_n | input | 1 | Carrier detect line, active low, asynchronous |
| status_rd | input | 1 | Status byte read strobe, one cycle per read |
| ctrl_wr | input | 1 | Control byte write strobe |
| wr_data | input | 8 | Write data for the control byte |
| msi_en | input | 1 | Modem-status interrupt enable |
| status_q | output | 8 | Status byte: live levels [7:4], change flags [3:0] |
| ctrl_q | output | 8 | Control byte read-back |
| dtr_n | output | 1 | Terminal-ready output, active low |
| rts_n | output | 1 | Request-to-send output, active low |
| out2_n | output | 1 | Auxiliary output 2, active low |
| msi_irq | output | 1 | Modem-status interrupt request |

## Verification
A pin change driven at a falling edge reaches the live status bit after two rising edges and the change flag after three. A control write changes the outputs and the looped live bits after one rising edge, and the looped change flags after two. Read clearing and `msi_irq` follow the read edge directly. The directed checks wait exactly these edge counts before sampling at the next falling edge, including a read placed on the very edge where a new change lands. The random phase compares every port at each falling edge against a bench model that advances edge by edge with the same latencies.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int NLINES = 4;  // line order: 0 CTS, 1 DSR, 2 RI, 3 DCD
  localparam int CTRL_W = 5;

  // Active-low line values seen in loop mode, taken from the control bits.
  function automatic logic [NLINES-1:0] loop_lines_n(input logic [CTRL_W-1:0] c);
    loop_lines_n = {~c[3], ~c[2], ~c[0], ~c[1]};
  endfunction

  // Change events: toggles for CTS/DSR/DCD, low-to-high only for RI.
  function automatic logic [NLINES-1:0] delta_events(input logic [NLINES-1:0] prev_n,
                                                      input logic [NLINES-1:0] cur_n);
    logic [NLINES-1:0] t;
    t = prev_n ^ cur_n;
    t[2] = ~prev_n[2] & cur_n[2];
    delta_events = t;
  endfunction

  function automatic logic [7:0] pack_status(input logic [NLINES-1:0] cur_n,
                                             input logic [NLINES-1:0] flags);
    pack_status = {~cur_n, flags};
  endfunction
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 4,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             mr,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (mr) stg[0] <= RST_VAL;
        else    stg[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (mr) stg[i] <= RST_VAL;
        else    stg[i] <= stg[i-1];
      end
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/mdm_delta.sv
module mdm_delta
  import mdm_pkg::*;
(
  input  logic              clk,
  input  logic              mr,
  input  logic [NLINES-1:0] line_n,
  input  logic              rd,
  output logic [NLINES-1:0] flags,
  output logic [NLINES-1:0] evt
);
  logic [NLINES-1:0] prev_n;

  assign evt = delta_events(prev_n, line_n);

  always_ff @(posedge clk) begin
    if (mr) begin
      prev_n <= '1;
      flags  <= '0;
    end else begin
      prev_n <= line_n;
      flags  <= (rd ? '0 : flags) | evt;
    end
  end

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (mr)
    !rd |=> ((flags & $past(flags)) == $past(flags)));  // R3
  AST_READ_KEEPS_NEW: assert property (@(posedge clk) disable iff (mr)
    rd |=> (flags == $past(evt)));  // R5
  AST_RI_FALL_SILENT: assert property (@(posedge clk) disable iff (mr)
    ($fell(line_n[2]) && rd) |=> !flags[2]);  // R4
endmodule

// File: rtl/mdm_ctrl_reg.sv
module mdm_ctrl_reg
  import mdm_pkg::*;
(
  input  logic              clk,
  input  logic              mr,
  input  logic              wr,
  input  logic [7:0]        wdata,
  output logic [CTRL_W-1:0] ctrl,
  output logic              dtr_n,
  output logic              rts_n,
  output logic              out2_n
);
  logic loop_on;
  logic unused_hi;

  assign unused_hi = ^wdata[7:CTRL_W];

  always_ff @(posedge clk) begin
    if (mr)      ctrl <= '0;
    else if (wr) ctrl <= wdata[CTRL_W-1:0];
  end

  assign loop_on = ctrl[4];
  assign dtr_n   = ~(ctrl[0] & ~loop_on);
  assign rts_n   = ~(ctrl[1] & ~loop_on);
  assign out2_n  = ~(ctrl[3] & ~loop_on);

  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (mr)
    wr |=> (ctrl == $past(wdata[CTRL_W-1:0])));  // R7
endmodule

// File: rtl/modem_ctl_unit.sv
module modem_ctl_unit
  import mdm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       mr,
  input  logic       cts_n,
  input  logic       dsr_n,
  input  logic       ri_n,
  input  logic       dcd_n,
  input  logic       status_rd,
  input  logic       ctrl_wr,
  input  logic [7:0] wr_data,
  input  logic       msi_en,
  output logic [7:0] status_q,
  output logic [7:0] ctrl_q,
  output logic       dtr_n,
  output logic       rts_n,
  output logic       out2_n,
  output logic       msi_irq
);
  logic [NLINES-1:0] pins_n, sync_n, eff_n, flags, evt;
  logic [CTRL_W-1:0] ctrl;
  logic              loop_on;

  assign pins_n = {dcd_n, ri_n, dsr_n, cts_n};

  mdm_sync #(.STAGES(SYNC_STAGES), .WIDTH(NLINES), .RST_VAL('1)) u_sync (
    .clk(clk), .mr(mr), .din(pins_n), .dout(sync_n));

  mdm_ctrl_reg u_ctrl (
    .clk(clk), .mr(mr), .wr(ctrl_wr), .wdata(wr_data), .ctrl(ctrl),
    .dtr_n(dtr_n), .rts_n(rts_n), .out2_n(out2_n));

  assign loop_on = ctrl[4];
  assign eff_n   = loop_on ? loop_lines_n(ctrl) : sync_n;

  mdm_delta u_delta (
    .clk(clk), .mr(mr), .line_n(eff_n), .rd(status_rd), .flags(flags), .evt(evt));

  assign status_q = pack_status(eff_n, flags);
  assign ctrl_q   = {{(8-CTRL_W){1'b0}}, ctrl};
  assign msi_irq  = msi_en & (|flags);

  AST_RESET_IDLE: assert property (@(posedge clk)
    mr |=> (dtr_n && rts_n && out2_n && !msi_irq && status_q[3:0] == 4'h0));  // R1
  AST_LOOP_QUIET: assert property (@(posedge clk) disable iff (mr)
    ctrl_q[4] |-> (dtr_n && rts_n && out2_n));  // R8
  AST_EVENT_FLAGGED: assert property (@(posedge clk) disable iff (mr)
    (|evt) |=> (status_q[3:0] != 4'h0));  // R3
  AST_IRQ_ON_EVENT: assert property (@(posedge clk) disable iff (mr)
    (|evt) |=> (msi_irq == msi_en));  // R6
endmodule

// File: tb/sim_modem_ctl_unit.sv
module sim_modem_ctl_unit;
  logic clk = 1'b0;
  logic mr = 1'b1;
  logic cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
  logic status_rd = 1'b0, ctrl_wr = 1'b0, msi_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] status_q, ctrl_q;
  logic dtr_n, rts_n, out2_n, msi_irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;  // 50 MHz

  modem_ctl_unit u0 (
    .clk(clk), .mr(mr), .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .dcd_n(dcd_n),
    .status_rd(status_rd), .ctrl_wr(ctrl_wr), .wr_data(wr_data), .msi_en(msi_en),
    .status_q(status_q), .ctrl_q(ctrl_q), .dtr_n(dtr_n), .rts_n(rts_n),
    .out2_n(out2_n), .msi_irq(msi_irq));

  // ---------------- bench model (per requirement) ----------------
  logic [3:0] m_s1 = 4'hF, m_s2 = 4'hF, m_prev = 4'hF, m_flags = 4'h0;
  logic [4:0] m_ctrl = 5'h0;

  // active levels (1 = asserted) in order CTS, DSR, RI, DCD
  function automatic logic [3:0] lvl_of(input logic [4:0] c, input logic [3:0] s2n);
    if (c[4]) return {c[3], c[2], c[0], c[1]};   // R8 loop sources
    return ~s2n;                                  // R2
  endfunction

  function automatic logic [3:0] ev_of(input logic [3:0] old_l, input logic [3:0] new_l);
    logic [3:0] e;
    e[0] = old_l[0] != new_l[0];
    e[1] = old_l[1] != new_l[1];
    e[3] = old_l[3] != new_l[3];
    e[2] = old_l[2] && !new_l[2];  // R4: ring going inactive
    return e;
  endfunction

  always @(posedge clk) begin
    if (mr) begin
      m_s1 <= 4'hF; m_s2 <= 4'hF; m_prev <= 4'hF; m_flags <= 4'h0; m_ctrl <= 5'h0;
    end else begin
      m_s1    <= {dcd_n, ri_n, dsr_n, cts_n};
      m_s2    <= m_s1;
      m_prev  <= ~lvl_of(m_ctrl, m_s2);
      m_flags <= (status_rd ? 4'h0 : m_flags) | ev_of(~m_prev, lvl_of(m_ctrl, m_s2));
      if (ctrl_wr) m_ctrl <= wr_data[4:0];
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read();
    status_rd = 1'b1; cyc(1); status_rd = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] d);
    wr_data = d; ctrl_wr = 1'b1; cyc(1); ctrl_wr = 1'b0;
  endtask

  task automatic model_compare();
    logic [3:0] l;
    logic [4:0] c;
    l = lvl_of(m_ctrl, m_s2);
    c = m_ctrl;
    chk("R2/R8 status", status_q, {l[3], l[2], l[1], l[0], m_flags});
    chk("R7 ctrl", ctrl_q, {3'b000, c});
    chk("R7/R8 outs", {5'b0, dtr_n, rts_n, out2_n},
        {5'b0, !(c[0] && !c[4]), !(c[1] && !c[4]), !(c[3] && !c[4])});
    chk("R6 irq", {7'b0, msi_irq}, {7'b0, msi_en && (m_flags != 0)});
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    cyc(3);
    // R1 reset state
    chk("R1 outs", {5'b0, dtr_n, rts_n, out2_n, msi_irq}, 8'h0E);
    chk("R1 ctrl", ctrl_q, 8'h00);
    mr = 1'b0; msi_en = 1'b1;
    cyc(1);
    chk("R1 after release", status_q, 8'h00);

    // R2/R3 CTS falling: live after 2 edges, flag after 3
    cts_n = 1'b0;
    cyc(1); chk("R2 not yet live", status_q, 8'h00);
    cyc(1); chk("R2 cts live", status_q, 8'h10);
    cyc(1); chk("R3 cts flag", status_q, 8'h11);
    chk("R6 irq raised", {7'b0, msi_irq}, 8'h01);
    cyc(3); chk("R3 flag sticky", status_q, 8'h11);
    do_read();
    chk("R5 read clears", status_q, 8'h10);
    chk("R6 irq cleared", {7'b0, msi_irq}, 8'h00);

    // R5 same-edge change and read
    cts_n = 1'b1; cyc(3);
    chk("R3 cts rise flag", status_q, 8'h01);
    dsr_n = 1'b0; cyc(2);
    do_read();
    chk("R5 event kept", status_q, 8'h22);

    // R4 ring: falling pin no flag, rising pin sets flag
    do_read();
    ri_n = 1'b0; cyc(4);
    chk("R4 ri fall", status_q, 8'h60);
    ri_n = 1'b1; cyc(3);
    chk("R4 ri rise", status_q, 8'h24);

    // R6 enable gating
    msi_en = 1'b0; cyc(1);
    chk("R6 gated", {7'b0, msi_irq}, 8'h00);
    msi_en = 1'b1; do_read();

    // R7 control outputs
    do_write(8'hEB);
    chk("R7 readback", ctrl_q, 8'h0B);
    chk("R7 outs low", {5'b0, dtr_n, rts_n, out2_n}, 8'h00);
    do_write(8'h02);
    chk("R7 rts only", {5'b0, dtr_n, rts_n, out2_n}, 8'h05);

    // R8 loop mode
    do_write(8'hFF);
    chk("R8 readback", ctrl_q, 8'h1F);
    chk("R8 outs high", {5'b0, dtr_n, rts_n, out2_n}, 8'h07);
    chk("R8 live all", {status_q[7:4], 4'h0}, 8'hF0);
    do_write(8'h12); cyc(1);
    do_read();
    chk("R8 cts from rts", status_q, 8'h10);
    cts_n = 1'b0; dsr_n = 1'b1; ri_n = 1'b0; dcd_n = 1'b0;
    cyc(5);
    chk("R8 pins ignored", status_q, 8'h10);
    do_write(8'h16); cyc(1);
    chk("R8 ri from out1", status_q, 8'h50);
    do_write(8'h12); cyc(1);
    chk("R8 looped ri flag", status_q[3:0], 8'h04);

    // R9 master reset mid-run
    do_write(8'h0B);
    cyc(4);
    mr = 1'b1; cyc(1); mr = 1'b0; cyc(1);
    chk("R9 ctrl cleared", ctrl_q, 8'h00);
    chk("R9 flags cleared", {4'h0, status_q[3:0]}, 8'h00);
    chk("R9 outs high irq low", {5'b0, dtr_n, rts_n, out2_n, msi_irq}, 8'h0E);

    // random phase against model
    for (int i = 0; i < 4000; i++) begin
      model_compare();
      if ($urandom_range(3) == 0) cts_n = ~cts_n;
      if ($urandom_range(3) == 0) dsr_n = ~dsr_n;
      if ($urandom_range(3) == 0) ri_n  = ~ri_n;
      if ($urandom_range(3) == 0) dcd_n = ~dcd_n;
      status_rd = ($urandom_range(4) == 0);
      ctrl_wr   = ($urandom_range(9) == 0);
      wr_data   = 8'($urandom);
      if ($urandom_range(19) == 0) msi_en = ~msi_en;
      mr = ($urandom_range(299) == 0);
      cyc(1);
    end
    mr = 1'b0; status_rd = 1'b0; ctrl_wr = 1'b0;
    cyc(1);
    model_compare();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule